// File: doc/BRIEF.md
# Paged External Bus Interface

This block drives the external data bus of a small 8-bit processor core. The core hands it one request at a time: which space to use (scratch-pad memory or I/O port), whether to read or write, an 8-bit offset with its addressing mode, and a write byte. The block runs a bus transaction of at least three clocks. It holds the address, the write data and one strobe steady across the transaction, and it stretches the last cycle while the slave holds READY low. When the transaction ends, it returns a one-cycle done pulse and the byte it read.

Both spaces share one address bus and one write-data bus. Each space has its own read-data input and its own read and write strobes. The upper address bits come from three page bytes that the core writes through a separate page-write port. With a wide bus all three page bytes sit above the offset. With a bus of 16 bits or fewer only the lowest page byte is used. Direct-mode offsets are limited to the first 32 locations of a page. Indirect-mode offsets reach all 256.

Top module: `ebi_top`

## Requirements
- R1: While reset is held and just after it, busy, done and all four strobes are low, rdata is 0x00, and the address and write-data buses are all zeros (pages and held offset are cleared).
- R2: A request (req_valid high) is taken only in a cycle where busy is low. busy rises in the next cycle. req_valid is ignored while busy is high.
- R3: Once a request is taken, busy, the address, the write data and the strobe stay steady for at least three cycles. The only exception is the address, which follows a page write.
- R4: In the third cycle and in every wait cycle, a low ready at the rising edge adds one more cycle. The transaction ends at the first edge where ready is high.
- R5: Space 0 (scratch-pad) asserts mem_rd for reads and mem_wr for writes. Space 1 (port) asserts io_rd or io_wr. Exactly one strobe is high while busy, and none is high otherwise.
- R6: At the ending edge a read captures mem_rdata or io_rdata, chosen by space. In the next cycle done is high for one cycle and rdata shows the byte. A write also pulses done but leaves rdata unchanged.
- R7: The address is {page2, page1, page0, offset} cut to its low AW bits when AW > 16, and {page0, offset} cut to AW bits when AW <= 16.
- R8: A page write with pg_sel 0, 1 or 2 loads page0, page1 or page2 from pg_data, and the address shows the new value in the next cycle. pg_sel 3 changes nothing.
- R9: With req_indirect low, offset bits [7:5] are forced to zero on the bus. With it high, all 8 offset bits are used.
- R10: A write request loads req_wdata onto the write-data bus. A read request leaves the write-data bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_space | input | 1 | 0 = scratch-pad, 1 = I/O port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = full 8-bit offset, 0 = 5-bit direct offset |
| req_offset | input | 8 | Offset inside the current page |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| pg_wr | input | 1 | Page register write enable |
| pg_sel | input | 2 | Page register select |
| pg_data | input | 8 | Page register value |
| ext_addr | output | AW | Shared external address |
| ext_wdata | output | 8 | Shared write data |
| mem_rd | output | 1 | Scratch-pad read strobe |
| mem_wr | output | 1 | Scratch-pad write strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| mem_rdata | input | 8 | Scratch-pad read data |
| io_rdata | input | 8 | Port read data |
| ready | input | 1 | Slave ready, sampled from the third cycle on |

## Verification
The bound checker checks, on every cycle, that at most one strobe is high, that a strobe appears only while busy, that every transaction is at least three cycles long, and that the address stays steady within a transaction unless a page write came just before. It also checks that done is a single-cycle pulse that follows a busy cycle with ready high. Only the bench scenarios can show the rest: the exact wait-state count for a given READY pattern, the captured byte and the space it came from, the page concatenation at the default width and at a narrow width, direct-mode truncation, and that requests during busy and page select 3 are ignored.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
   localparam int OFS_W  = 8;
   localparam int DATA_W = 8;
   localparam int NPAGES = 3;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ADR    = 2'd1,
      ST_HOLD   = 2'd2,
      ST_SAMPLE = 2'd3
   } ebi_state_e;

   typedef enum logic {
      SP_SCRATCH = 1'b0,
      SP_PORT    = 1'b1
   } ebi_space_e;
endpackage

// File: rtl/ebi_page_regs.sv
module ebi_page_regs
   import ebi_pkg::*;
#(
   parameter int NP = NPAGES
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pg_wr,
   input  logic [1:0]                  pg_sel,
   input  logic [DATA_W-1:0]           pg_data,
   output logic [NP-1:0][DATA_W-1:0]   pages
);
   for (genvar gi = 0; gi < NP; gi++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pages[gi] <= '0;
         else if (pg_wr && (pg_sel == 2'(gi)))
            pages[gi] <= pg_data;
      end
   end
endmodule

// File: rtl/ebi_addr_mux.sv
module ebi_addr_mux
   import ebi_pkg::*;
#(
   parameter int AW = 24,
   parameter int NP = NPAGES
) (
   input  logic [NP-1:0][DATA_W-1:0] pages,
   input  logic [OFS_W-1:0]          offset,
   output logic [AW-1:0]             ext_addr
);
   localparam int WIDE_W   = NP * DATA_W + OFS_W;
   localparam int NARROW_W = DATA_W + OFS_W;

   if (AW > 16) begin : g_wide
      logic [WIDE_W-1:0] full;
      always_comb begin
         full = {pages, offset};
         ext_addr = full[AW-1:0];
      end
   end else begin : g_narrow
      logic [NARROW_W-1:0] full;
      always_comb begin
         full = {pages[0], offset};
         ext_addr = full[AW-1:0];
      end
   end
endmodule

// File: rtl/ebi_seq.sv
module ebi_seq
   import ebi_pkg::*;
#(
   parameter int DIRECT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_space,
   input  logic              req_write,
   input  logic              req_indirect,
   input  logic [OFS_W-1:0]  req_offset,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ready,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic              busy,
   output logic [OFS_W-1:0]  off_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [OFS_W-1:0] DMASK = OFS_W'((1 << DIRECT_W) - 1);

   ebi_state_e state, state_nx;
   ebi_space_e space_q;
   logic       write_q;
   logic       accept;
   logic       finish;

   assign accept = (state == ST_IDLE) && req_valid;
   assign finish = (state == ST_SAMPLE) && ready;
   assign busy   = (state != ST_IDLE);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:   if (req_valid) state_nx = ST_ADR;
         ST_ADR:    state_nx = ST_HOLD;
         ST_HOLD:   state_nx = ST_SAMPLE;
         ST_SAMPLE: if (ready) state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         space_q <= SP_SCRATCH;
         write_q <= 1'b0;
         off_q   <= '0;
         wdata_q <= '0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         state <= state_nx;
         done  <= finish;
         if (accept) begin
            space_q <= ebi_space_e'(req_space);
            write_q <= req_write;
            off_q   <= req_indirect ? req_offset : (req_offset & DMASK);
            if (req_write)
               wdata_q <= req_wdata;
         end
         if (finish && !write_q)
            rdata <= (space_q == SP_PORT) ? io_rdata : mem_rdata;
      end
   end

   always_comb begin
      mem_rd = busy && (space_q == SP_SCRATCH) && !write_q;
      mem_wr = busy && (space_q == SP_SCRATCH) &&  write_q;
      io_rd  = busy && (space_q == SP_PORT)    && !write_q;
      io_wr  = busy && (space_q == SP_PORT)    &&  write_q;
   end
endmodule

// File: rtl/ebi_top.sv
module ebi_top
   import ebi_pkg::*;
#(
   parameter int AW       = 24,
   parameter int DIRECT_W = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_space,
   input  logic          req_write,
   input  logic          req_indirect,
   input  logic [7:0]    req_offset,
   input  logic [7:0]    req_wdata,
   output logic          busy,
   output logic          done,
   output logic [7:0]    rdata,
   input  logic          pg_wr,
   input  logic [1:0]    pg_sel,
   input  logic [7:0]    pg_data,
   output logic [AW-1:0] ext_addr,
   output logic [7:0]    ext_wdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          io_rd,
   output logic          io_wr,
   input  logic [7:0]    mem_rdata,
   input  logic [7:0]    io_rdata,
   input  logic          ready
);
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("ebi_top: AW must lie in 8..32");
   end
   if (DIRECT_W < 1 || DIRECT_W > OFS_W) begin : g_bad_dw
      $error("ebi_top: DIRECT_W must lie in 1..8");
   end

   logic [NPAGES-1:0][DATA_W-1:0] pages;
   logic [OFS_W-1:0]              off_q;

   ebi_page_regs #(.NP(NPAGES)) u_pages (
      .clk     (clk),
      .rst_n   (rst_n),
      .pg_wr   (pg_wr),
      .pg_sel  (pg_sel),
      .pg_data (pg_data),
      .pages   (pages)
   );

   ebi_seq #(.DIRECT_W(DIRECT_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_space    (req_space),
      .req_write    (req_write),
      .req_indirect (req_indirect),
      .req_offset   (req_offset),
      .req_wdata    (req_wdata),
      .ready        (ready),
      .mem_rdata    (mem_rdata),
      .io_rdata     (io_rdata),
      .busy         (busy),
      .off_q        (off_q),
      .wdata_q      (ext_wdata),
      .mem_rd       (mem_rd),
      .mem_wr       (mem_wr),
      .io_rd        (io_rd),
      .io_wr        (io_wr),
      .done         (done),
      .rdata        (rdata)
   );

   ebi_addr_mux #(.AW(AW), .NP(NPAGES)) u_amux (
      .pages    (pages),
      .offset   (off_q),
      .ext_addr (ext_addr)
   );
endmodule

// File: rtl/ebi_chk.sv
module ebi_chk #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          ready,
   input logic          pg_wr,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic          io_rd,
   input logic          io_wr,
   input logic [AW-1:0] ext_addr
);
   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

   a_r5_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr) |-> busy);

   a_r3_min_three: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy ##1 busy);

   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(pg_wr)) |-> $stable(ext_addr));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(busy) && $past(ready)));

   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind ebi_top ebi_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .ready    (ready),
   .pg_wr    (pg_wr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .ext_addr (ext_addr)
);

// File: tb/tb_ebi_top.sv
`timescale 1ns/1ps
module tb_ebi_top;
   localparam int AW  = 24;
   localparam int AWN = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_space = 0, req_write = 0, req_indirect = 0;
   logic [7:0] req_offset = 0, req_wdata = 0;
   logic pg_wr = 0;
   logic [1:0] pg_sel = 0;
   logic [7:0] pg_data = 0, mem_rdata = 8'h3C, io_rdata = 8'hC5;
   logic ready = 1'b1;

   logic busy, done, mem_rd, mem_wr, io_rd, io_wr;
   logic [7:0] rdata, ext_wdata;
   logic [AW-1:0] ext_addr;
   logic busy_n, done_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
   logic [7:0] rdata_n, ext_wdata_n;
   logic [AWN-1:0] ext_addr_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ebi_top #(.AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
      .req_write(req_write), .req_indirect(req_indirect), .req_offset(req_offset),
      .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
      .pg_wr(pg_wr), .pg_sel(pg_sel), .pg_data(pg_data), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
      .io_wr(io_wr), .mem_rdata(mem_rdata), .io_rdata(io_rdata), .ready(ready));

   ebi_top #(.AW(AWN)) dut_narrow (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
      .req_write(req_write), .req_indirect(req_indirect), .req_offset(req_offset),
      .req_wdata(req_wdata), .busy(busy_n), .done(done_n), .rdata(rdata_n),
      .pg_wr(pg_wr), .pg_sel(pg_sel), .pg_data(pg_data), .ext_addr(ext_addr_n),
      .ext_wdata(ext_wdata_n), .mem_rd(mem_rd_n), .mem_wr(mem_wr_n), .io_rd(io_rd_n),
      .io_wr(io_wr_n), .mem_rdata(mem_rdata), .io_rdata(io_rdata), .ready(ready));

   // Behavioural reference: phase counter plus held request fields
   int         m_phase;
   logic [7:0] m_page [3];
   logic [7:0] m_off, m_wd, m_rd;
   logic       m_space, m_write, m_done;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_off = 0; m_wd = 0; m_rd = 0; m_done = 0;
         m_space = 0; m_write = 0;
         for (int i = 0; i < 3; i++) m_page[i] = 8'h00;
      end else begin
         m_done = 0;
         if (m_phase == 0) begin
            if (req_valid) begin
               m_phase = 1; m_space = req_space; m_write = req_write;
               m_off = req_indirect ? req_offset : {3'b000, req_offset[4:0]};
               if (req_write) m_wd = req_wdata;
            end
         end else if (m_phase < 3) begin
            m_phase = m_phase + 1;
         end else if (ready) begin
            m_phase = 0; m_done = 1;
            if (!m_write) m_rd = m_space ? io_rdata : mem_rdata;
         end
         if (pg_wr && pg_sel != 2'd3) m_page[pg_sel] = pg_data;
      end
   end

   function automatic logic [31:0] m_addr(int w);
      logic [31:0] full;
      if (w > 16) full = {m_page[2], m_page[1], m_page[0], m_off};
      else        full = {16'h0, m_page[0], m_off};
      return full & ((64'd1 << w) - 1);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // Per-cycle comparison, 2 ns after each rising edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         logic mb;
         mb = (m_phase != 0);
         chk("R2 busy", busy, mb);
         chk("R5 mem_rd", mem_rd, mb && !m_space && !m_write);
         chk("R5 mem_wr", mem_wr, mb && !m_space &&  m_write);
         chk("R5 io_rd",  io_rd,  mb &&  m_space && !m_write);
         chk("R5 io_wr",  io_wr,  mb &&  m_space &&  m_write);
         chk("R7 addr wide",   ext_addr,   m_addr(AW));
         chk("R7 addr narrow", ext_addr_n, m_addr(AWN));
         chk("R10 wdata", ext_wdata, m_wd);
         chk("R6 done", done, m_done);
         chk("R6 rdata", rdata, m_rd);
         chk("R6 narrow done", done_n, m_done);
      end
   end

   // Runs one transaction; returns negedges from request to done
   task automatic txn(input logic sp, input logic wr, input logic ind,
                      input logic [7:0] off, input logic [7:0] wd,
                      input int waits, input bit spam, output int n);
      @(negedge clk);
      req_valid = 1; req_space = sp; req_write = wr; req_indirect = ind;
      req_offset = off; req_wdata = wd; ready = (waits == 0);
      n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (done) break;
         if (spam && n < 3 + waits) begin
            req_valid = 1; req_space = ~sp; req_write = ~wr;
            req_offset = ~off; req_wdata = ~wd; req_indirect = 1;
         end else begin
            req_valid = 0;
         end
         ready = (n >= 3 + waits);
      end
      req_valid = 0; ready = 1;
   endtask

   task automatic page(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      pg_wr = 1; pg_sel = s; pg_data = d;
      @(negedge clk);
      pg_wr = 0;
   endtask

   initial begin
      int n;
      fork
         begin
            repeat (2) @(negedge clk);
            chk("R1 busy in reset", busy, 0);
            chk("R1 strobes in reset", {mem_rd, mem_wr, io_rd, io_wr}, 0);
            chk("R1 addr in reset", ext_addr, 0);
            chk("R1 done in reset", done, 0);
            rst_n = 1;
            @(negedge clk);
            chk("R1 rdata after reset", rdata, 0);
            chk("R1 wdata after reset", ext_wdata, 0);

            page(2'd0, 8'hA1); page(2'd1, 8'hB2); page(2'd2, 8'hC3);
            chk("R8 pages wide", ext_addr, 24'hB2A100);
            chk("R8 pages narrow", ext_addr_n, 12'h100);
            page(2'd3, 8'hFF);
            chk("R8 sel3 ignored", ext_addr, 24'hB2A100);

            txn(0, 0, 1, 8'hE7, 8'h00, 0, 0, n);
            chk("R3 no-wait length", n, 4);
            chk("R6 scratch read", rdata, 8'h3C);
            chk("R9 indirect offset", ext_addr, 24'hB2A1E7);

            io_rdata = 8'h96;
            txn(1, 0, 0, 8'hFF, 8'h00, 3, 0, n);
            chk("R4 three waits", n, 7);
            chk("R6 port read", rdata, 8'h96);
            chk("R9 direct offset", ext_addr[7:0], 8'h1F);

            txn(1, 1, 1, 8'h42, 8'h5D, 1, 1, n);
            chk("R4 one wait", n, 5);
            chk("R2 spam ignored wdata", ext_wdata, 8'h5D);
            chk("R10 write data", ext_wdata, 8'h5D);
            chk("R6 write keeps rdata", rdata, 8'h96);

            txn(0, 1, 0, 8'h3B, 8'h77, 0, 1, n);
            chk("R2 spam ignored length", n, 4);
            chk("R9 direct write", ext_addr[7:0], 8'h1B);

            mem_rdata = 8'hE1;
            txn(0, 0, 1, 8'h80, 8'h11, 5, 0, n);
            chk("R4 five waits", n, 9);
            chk("R10 read keeps wdata", ext_wdata, 8'h77);
            chk("R6 captured", rdata, 8'hE1);

            fork
               txn(1, 0, 1, 8'h10, 8'h00, 2, 0, n);
               begin
                  repeat (2) @(negedge clk);
                  pg_wr = 1; pg_sel = 2'd0; pg_data = 8'h5E;
                  @(negedge clk);
                  pg_wr = 0;
                  chk("R8 page during txn", ext_addr, 24'hB25E10);
               end
            join
            chk("R4 two waits", n, 6);
            repeat (3) @(negedge clk);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule